// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block reads 16-bit words from a three-wire serial EEPROM (chip select, shift clock, serial data out to the part, serial data back from the part). A one-cycle request with a word address starts an access. The block raises chip select and shifts out a start bit, the two-bit read opcode and the address. It then collects sixteen data bits and reports them with a one-cycle completion strobe.

The block does not assume a fixed address width. On the first access after reset it probes the part. It clocks out zero address bits and watches the data line. The part pulls the line low once it has taken its whole address, and the number of address bits clocked before that low bit is the part's address width: 6 for a 64-word part, 8 for a 256-word part. That probe access always returns word 0. Later accesses shift exactly the learned number of address bits. If no low bit appears, the access ends with an error and the width falls back to 6 bits.

The shift clock is the system clock divided by a parameter. Outgoing data changes only while the shift clock is low. Incoming data is sampled on the system clock edge that raises the shift clock.

Top module: `uwire_rom_reader`

## Requirements
- R1: After reset, chip select, shift clock and serial data out are low, and busy, done, error and width-valid are all low.
- R2: Every accepted access presents the bits 1, 1, 0 on serial data out over the first three shift-clock rising edges after chip select rises. Serial data out never changes on a cycle in which the shift clock rises.
- R3: While the width is unknown, the block sends zero address bits and samples the data line at each rising edge. The first low sample after at least one address bit sets the width to the number of address bits already clocked and sets width-valid. The access then returns word 0, and the width stays fixed until the next reset.
- R4: Once the width is known, the block sends the low width-many bits of the requested address, most significant first. Higher address bits have no effect on the word read.
- R5: After the low marker bit, sixteen data bits are sampled most significant first. The assembled word appears on the data output in the same cycle as a one-cycle done pulse.
- R6: If the probe sees no low sample within 8 address bits, the access ends with done and error together. The width becomes 6 with width-valid set, and the data output keeps its previous value.
- R7: With a known width, if the data line is not low at the rising edge after the last address bit, the access ends with done and error, and the data output keeps its previous value.
- R8: Chip select drops when the access ends. It stays low for at least 2*CLK_DIV system clock cycles before the next access raises it, and the shift clock is low whenever chip select is low.
- R9: A request made while busy is high is ignored: it starts no access and does not change the word returned by the access in progress.
- R10: Each high phase of the shift clock lasts exactly CLK_DIV system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start an access (accepted when not busy) |
| addr_i | input | MAX_AW | Word address of the access |
| busy_o | output | 1 | Access or inter-access gap in progress |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Access failed (valid with done_o) |
| data_o | output | DATA_W | Last word read successfully |
| aw_o | output | $clog2(MAX_AW+1) | Learned address width |
| aw_valid_o | output | 1 | Address width has been learned |
| cs_o | output | 1 | EEPROM chip select |
| sk_o | output | 1 | EEPROM shift clock |
| di_o | output | 1 | Serial data to the EEPROM |
| do_i | input | 1 | Serial data from the EEPROM |

## Verification
The bench drives a behavioural serial part that can be set to 6 or 8 address bits, or removed so that the data line stays high.

- **Width probe.** It probes both sizes and checks the learned width and the word-0 result. A design that counted the marker one slot late or early would report 7 or 9 bits. It would also return a shifted word.
- **Address truncation.** It reads addresses whose upper bits lie beyond a 6-bit part's range. A design that shifted all eight bits would fetch the wrong word.
- **Failure paths.** It exercises the missing part, and it changes the part's size after the width is learned. A design that did not check the marker bit would report stale or garbage data instead of an error.
- **Timing and busy handling.** It measures the shift-clock high phase and the chip-select gap between back-to-back accesses. It also issues a request while busy. A design that ignored busy would start a second access.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_TAIL = 2'd2,
    SEQ_GAP  = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } seq_phase_e;

  // start bit, then the two-bit read opcode, sent from bit 2 down to bit 0
  localparam logic [2:0] READ_PREAMBLE = 3'b110;
  localparam int         PREAMBLE_LEN  = 3;

endpackage

// File: rtl/uwire_sk_gen.sv
module uwire_sk_gen #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);

  generate
    if (CLK_DIV <= 1) begin : g_nodiv
      assign tick_o = en_i;
    end else begin : g_div
      localparam int CW = $clog2(CLK_DIV);
      localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

      logic [CW-1:0] cnt_q, cnt_d;
      logic          tick_d;

      always_comb begin
        cnt_d  = cnt_q;
        tick_d = 1'b0;
        if (!en_i) begin
          cnt_d = '0;
        end else if (cnt_q == LAST) begin
          cnt_d  = '0;
          tick_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick_o = tick_d;
    end
  endgenerate

endmodule

// File: rtl/uwire_width_det.sv
module uwire_width_det #(
  parameter int MAX_AW      = 8,
  parameter int FALLBACK_AW = 6,
  parameter int AWW         = $clog2(MAX_AW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           found_i,
  input  logic [AWW-1:0] found_w_i,
  input  logic           fail_i,
  output logic [AWW-1:0] aw_o,
  output logic           valid_o
);

  logic [AWW-1:0] aw_q, aw_d;
  logic           valid_q, valid_d;

  always_comb begin
    aw_d    = aw_q;
    valid_d = valid_q;
    if (!valid_q) begin
      if (found_i) begin
        aw_d    = found_w_i;
        valid_d = 1'b1;
      end else if (fail_i) begin
        aw_d    = AWW'(FALLBACK_AW);
        valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      aw_q    <= aw_d;
      valid_q <= valid_d;
    end
  end

  assign aw_o    = aw_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/uwire_seq.sv
module uwire_seq
  import uwire_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MAX_AW = 8,
  parameter int AWW    = $clog2(MAX_AW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [MAX_AW-1:0] addr_i,
  input  logic              do_i,
  input  logic              tick_i,
  input  logic [AWW-1:0]    aw_i,
  input  logic              aw_valid_i,
  output logic              en_o,
  output logic              found_o,
  output logic [AWW-1:0]    found_w_o,
  output logic              fail_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int CNT_MAX = (DATA_W > MAX_AW + 1) ? DATA_W : MAX_AW + 1;
  localparam int CNTW    = $clog2(CNT_MAX + 1);
  localparam logic [CNTW-1:0] K_CMD_LAST  = CNTW'(PREAMBLE_LEN - 1);
  localparam logic [CNTW-1:0] K_DATA_LAST = CNTW'(DATA_W - 1);
  localparam logic [CNTW-1:0] K_PROBE_MAX = CNTW'(MAX_AW);

  seq_state_e        state_q, state_d;
  seq_phase_e        phase_q, phase_d;
  logic [CNTW-1:0]   k_q, k_d;
  logic [MAX_AW-1:0] ash_q, ash_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              cs_q, cs_d, sk_q, sk_d, di_q, di_d;
  logic              done_q, done_d, err_q, err_d;
  logic              slot_bit;
  logic              k_at_aw;

  assign k_at_aw = (int'(k_q) == int'(aw_i));

  // bit to present for the slot described by phase_q / k_q
  always_comb begin
    slot_bit = 1'b0;
    unique case (phase_q)
      PH_CMD:  slot_bit = READ_PREAMBLE[K_CMD_LAST - k_q];
      PH_ADDR: slot_bit = ash_q[MAX_AW-1];
      default: slot_bit = 1'b0;
    endcase
  end

  always_comb begin
    state_d   = state_q;
    phase_d   = phase_q;
    k_d       = k_q;
    ash_d     = ash_q;
    shift_d   = shift_q;
    data_d    = data_q;
    cs_d      = cs_q;
    sk_d      = sk_q;
    di_d      = di_q;
    done_d    = 1'b0;
    err_d     = 1'b0;
    found_o   = 1'b0;
    found_w_o = AWW'(k_q);
    fail_o    = 1'b0;

    unique case (state_q)
      SEQ_IDLE: begin
        if (req_i) begin
          state_d = SEQ_RUN;
          phase_d = PH_CMD;
          k_d     = '0;
          cs_d    = 1'b1;
          sk_d    = 1'b0;
          di_d    = READ_PREAMBLE[PREAMBLE_LEN-1];
          ash_d   = aw_valid_i ? (addr_i << (MAX_AW - int'(aw_i))) : '0;
        end
      end

      SEQ_RUN: begin
        if (tick_i) begin
          if (!sk_q) begin
            // rising shift clock: sample the part and advance the slot
            sk_d = 1'b1;
            unique case (phase_q)
              PH_CMD: begin
                if (k_q == K_CMD_LAST) begin
                  phase_d = PH_ADDR;
                  k_d     = '0;
                end else begin
                  k_d = k_q + 1'b1;
                end
              end
              PH_ADDR: begin
                ash_d = ash_q << 1;
                if (!aw_valid_i) begin
                  if (!do_i && (k_q != '0)) begin
                    found_o = 1'b1;
                    phase_d = PH_DATA;
                    k_d     = '0;
                  end else if (k_q == K_PROBE_MAX) begin
                    fail_o  = 1'b1;
                    state_d = SEQ_TAIL;
                    done_d  = 1'b1;
                    err_d   = 1'b1;
                  end else begin
                    k_d = k_q + 1'b1;
                  end
                end else if (k_at_aw) begin
                  if (!do_i) begin
                    phase_d = PH_DATA;
                    k_d     = '0;
                  end else begin
                    state_d = SEQ_TAIL;
                    done_d  = 1'b1;
                    err_d   = 1'b1;
                  end
                end else begin
                  k_d = k_q + 1'b1;
                end
              end
              default: begin
                shift_d = {shift_q[DATA_W-2:0], do_i};
                if (k_q == K_DATA_LAST) begin
                  data_d  = {shift_q[DATA_W-2:0], do_i};
                  state_d = SEQ_TAIL;
                  done_d  = 1'b1;
                end else begin
                  k_d = k_q + 1'b1;
                end
              end
            endcase
          end else begin
            // falling shift clock: present the bit of the current slot
            sk_d = 1'b0;
            di_d = slot_bit;
          end
        end
      end

      SEQ_TAIL: begin
        if (tick_i) begin
          sk_d    = 1'b0;
          cs_d    = 1'b0;
          di_d    = 1'b0;
          k_d     = '0;
          state_d = SEQ_GAP;
        end
      end

      default: begin
        if (tick_i) begin
          if (k_q == CNTW'(1)) begin
            state_d = SEQ_IDLE;
            k_d     = '0;
          end else begin
            k_d = k_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      phase_q <= PH_CMD;
      k_q     <= '0;
      ash_q   <= '0;
      shift_q <= '0;
      data_q  <= '0;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      di_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      k_q     <= k_d;
      ash_q   <= ash_d;
      shift_q <= shift_d;
      data_q  <= data_d;
      cs_q    <= cs_d;
      sk_q    <= sk_d;
      di_q    <= di_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign en_o   = (state_q != SEQ_IDLE);
  assign busy_o = (state_q != SEQ_IDLE);
  assign cs_o   = cs_q;
  assign sk_o   = sk_q;
  assign di_o   = di_q;
  assign done_o = done_q;
  assign err_o  = err_q;
  assign data_o = data_q;

endmodule

// File: rtl/uwire_rom_reader.sv
module uwire_rom_reader #(
  parameter int CLK_DIV     = 2,
  parameter int DATA_W      = 16,
  parameter int MAX_AW      = 8,
  parameter int FALLBACK_AW = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_i,
  input  logic [MAX_AW-1:0]            addr_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic                         err_o,
  output logic [DATA_W-1:0]            data_o,
  output logic [$clog2(MAX_AW+1)-1:0]  aw_o,
  output logic                         aw_valid_o,
  output logic                         cs_o,
  output logic                         sk_o,
  output logic                         di_o,
  input  logic                         do_i
);

  localparam int AWW = $clog2(MAX_AW + 1);

  // asynchronous assert, synchronous release
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic           tick, en;
  logic           found, fail;
  logic [AWW-1:0] found_w;

  uwire_sk_gen #(.CLK_DIV(CLK_DIV)) u_skgen (
    .clk    (clk),
    .rst_n  (rst_s2_q),
    .en_i   (en),
    .tick_o (tick)
  );

  uwire_width_det #(
    .MAX_AW      (MAX_AW),
    .FALLBACK_AW (FALLBACK_AW),
    .AWW         (AWW)
  ) u_wdet (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .found_i   (found),
    .found_w_i (found_w),
    .fail_i    (fail),
    .aw_o      (aw_o),
    .valid_o   (aw_valid_o)
  );

  uwire_seq #(
    .DATA_W (DATA_W),
    .MAX_AW (MAX_AW),
    .AWW    (AWW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_s2_q),
    .req_i      (req_i),
    .addr_i     (addr_i),
    .do_i       (do_i),
    .tick_i     (tick),
    .aw_i       (aw_o),
    .aw_valid_i (aw_valid_o),
    .en_o       (en),
    .found_o    (found),
    .found_w_o  (found_w),
    .fail_o     (fail),
    .cs_o       (cs_o),
    .sk_o       (sk_o),
    .di_o       (di_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .data_o     (data_o)
  );

endmodule

// File: rtl/uwire_rom_reader_chk.sv
module uwire_rom_reader_chk #(
  parameter int CLK_DIV = 2,
  parameter int MAX_AW  = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        busy_o,
  input logic                        done_o,
  input logic                        err_o,
  input logic [$clog2(MAX_AW+1)-1:0] aw_o,
  input logic                        aw_valid_o,
  input logic                        cs_o,
  input logic                        sk_o,
  input logic                        di_o
);

  localparam int GAP_MIN = 2 * CLK_DIV;
  localparam int GW      = $clog2(GAP_MIN + 2) + 1;
  localparam int HW      = $clog2(CLK_DIV + 2) + 1;

  logic [GW-1:0] gap_q;
  logic [HW-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= GW'(GAP_MIN);
      hi_q  <= '0;
    end else begin
      if (cs_o)                    gap_q <= '0;
      else if (gap_q < GW'(GAP_MIN)) gap_q <= gap_q + 1'b1;
      if (!sk_o)                   hi_q <= '0;
      else if (hi_q < HW'(CLK_DIV + 1)) hi_q <= hi_q + 1'b1;
    end
  end

  a_r8_sk_low_without_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_o |-> !sk_o);

  a_r8_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_o) |-> (gap_q >= GW'(GAP_MIN)));

  a_r2_di_still_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sk_o) |-> $stable(di_o));

  a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_err_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  a_r9_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  a_r3_width_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid_o |=> (aw_valid_o && $stable(aw_o)));

  a_r10_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sk_o) |-> (hi_q == HW'(CLK_DIV)));

endmodule

bind uwire_rom_reader uwire_rom_reader_chk #(
  .CLK_DIV (CLK_DIV),
  .MAX_AW  (MAX_AW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .aw_o       (aw_o),
  .aw_valid_o (aw_valid_o),
  .cs_o       (cs_o),
  .sk_o       (sk_o),
  .di_o       (di_o)
);

// File: tb/uwire_rom_reader_test.sv
`timescale 1ns/1ps
module uwire_rom_reader_test;

  localparam int CLK_DIV = 2;

  logic        clk, rst_n, req, do_line;
  logic [7:0]  addr;
  logic        busy, done, err, aw_valid, cs, sk, di;
  logic [15:0] data;
  logic [3:0]  aw;

  int checks = 0, errors = 0, cyc = 0;

  uwire_rom_reader #(.CLK_DIV(CLK_DIV)) uut (
    .clk (clk), .rst_n (rst_n), .req_i (req), .addr_i (addr),
    .busy_o (busy), .done_o (done), .err_o (err), .data_o (data),
    .aw_o (aw), .aw_valid_o (aw_valid), .cs_o (cs), .sk_o (sk),
    .di_o (di), .do_i (do_line)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  // ---------------- behavioural serial part ----------------
  logic [15:0] mem [256];
  int          m_aw = 8;
  bit          m_present = 1'b1;
  logic        m_do;
  int          m_cnt, m_didx, cmd_bad;
  logic [2:0]  m_cmd;
  logic [7:0]  m_addr;

  initial begin
    m_do = 1'b1; m_cnt = 0; m_didx = -1; cmd_bad = 0; m_cmd = '0; m_addr = '0;
    for (int i = 0; i < 256; i++) mem[i] = 16'hA000 ^ 16'(i * 16'h0123);
    mem[0]  = 16'h5AC3;
    mem[63] = 16'hFFFF;
  end

  always @(posedge sk) if (cs) begin
    if (m_cnt < 3) begin
      m_cmd = {m_cmd[1:0], di};
      m_cnt++;
      if (m_cnt == 3 && m_cmd != 3'b110) cmd_bad++;
    end else if (m_cnt < 3 + m_aw) begin
      m_addr = {m_addr[6:0], di};
      m_cnt++;
      if (m_cnt == 3 + m_aw) begin m_do = 1'b0; m_didx = 15; end
    end else if (m_didx >= 0) begin
      m_do = mem[m_addr][m_didx];
      m_didx--;
    end else begin
      m_do = 1'b1;
    end
  end

  always @(negedge cs) begin
    m_cnt = 0; m_do = 1'b1; m_addr = '0; m_didx = -1;
  end

  assign do_line = m_present ? m_do : 1'b1;

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    req = 1'b0; addr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] a, output bit got_err, output int lat);
    @(negedge clk);
    req = 1'b1; addr = a;
    @(negedge clk);
    req = 1'b0;
    lat = 0;
    while (!done && lat < 2000) begin
      @(posedge clk); #1; lat++;
    end
    got_err = err;
    while (busy && lat < 4000) begin @(negedge clk); lat++; end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    check(cs == 0 && sk == 0 && di == 0, "R1 serial pins idle", {cs, sk, di}, 0);
    check(busy == 0 && done == 0 && err == 0, "R1 status idle", {busy, done, err}, 0);
    check(aw_valid == 0, "R1 width not valid", aw_valid, 0);
  endtask

  task automatic t_probe(input int part_aw, input logic [7:0] a);
    bit e; int l;
    m_aw = part_aw;
    do_read(a, e, l);
    check(e == 0, "R3 probe no error", e, 0);
    check(aw_valid == 1 && aw == 4'(part_aw), "R3 learned width", aw, part_aw);
    check(data == mem[0], "R3 probe returns word 0", data, mem[0]);
    check(cmd_bad == 0, "R2 preamble 1,1,0", cmd_bad, 0);
  endtask

  task automatic t_read(input logic [7:0] a, input logic [7:0] mask, input string tag);
    bit e; int l;
    logic [15:0] exp;
    exp = mem[a & mask];
    do_read(a, e, l);
    check(e == 0, {tag, " no error"}, e, 0);
    check(data == exp, tag, data, exp);
  endtask

  task automatic t_timing();
    int hi, lo, guard;
    // R10: length of one shift-clock high phase
    @(negedge clk); req = 1'b1; addr = 8'h11;
    @(negedge clk); req = 1'b0;
    guard = 0;
    while (!sk && guard < 100) begin @(negedge clk); guard++; end
    hi = 0;
    while (sk && hi < 100) begin @(negedge clk); hi++; end
    check(hi == CLK_DIV, "R10 high phase length", hi, CLK_DIV);
    while (busy && guard < 4000) begin @(negedge clk); guard++; end
    // R8: back-to-back requests, measure chip-select low time
    @(negedge clk); req = 1'b1; addr = 8'h22;
    guard = 0;
    while (!cs && guard < 100) begin @(negedge clk); guard++; end
    while (cs && guard < 4000) begin @(negedge clk); guard++; end
    lo = 0;
    while (!cs && lo < 200) begin @(negedge clk); lo++; end
    req = 1'b0;
    check(lo >= 2 * CLK_DIV, "R8 chip-select gap", lo, 2 * CLK_DIV);
    guard = 0;
    while (busy && guard < 4000) begin @(negedge clk); guard++; end
  endtask

  task automatic t_busy_ignored();
    int guard, starts;
    logic [15:0] exp;
    exp = mem[8'h33];
    @(negedge clk); req = 1'b1; addr = 8'h33;
    @(negedge clk); req = 1'b0;
    repeat (10) @(negedge clk);
    req = 1'b1; addr = 8'h44;
    @(negedge clk); req = 1'b0;
    guard = 0;
    while (busy && guard < 4000) begin @(negedge clk); guard++; end
    check(data == exp, "R9 word of first access kept", data, exp);
    starts = 0;
    repeat (40) begin @(negedge clk); if (cs || busy) starts++; end
    check(starts == 0, "R9 no second access", starts, 0);
  endtask

  task automatic t_missing_part();
    bit e; int l;
    m_present = 1'b0;
    do_read(8'h10, e, l);
    check(e == 1, "R6 error when marker absent", e, 1);
    check(aw_valid == 1 && aw == 4'd6, "R6 fallback width", aw, 6);
    check(data == 16'h0000, "R6 data unchanged", data, 0);
    m_present = 1'b1;
    m_aw = 6;
    t_read(8'h21, 8'h3F, "R6 fallback width reads");
  endtask

  task automatic t_wrong_marker();
    bit e; int l;
    logic [15:0] prev;
    prev = data;
    m_aw = 6;  // part shrinks while 8 bits are already learned
    do_read(8'hFC, e, l);
    check(e == 1, "R7 marker check error", e, 1);
    check(data == prev, "R7 data unchanged", data, prev);
  endtask

  // ---------------- main ----------------
  initial begin
    do_reset();
    t_reset_state();

    t_probe(8, 8'h37);
    t_read(8'h37, 8'hFF, "R4 R5 read 8-bit 37");
    t_read(8'hA5, 8'hFF, "R4 R5 read 8-bit A5");
    t_read(8'hFF, 8'hFF, "R5 read 8-bit FF");
    t_timing();
    t_busy_ignored();

    do_reset();
    t_reset_state();
    t_probe(6, 8'h12);
    t_read(8'h45, 8'h3F, "R4 upper bits ignored");
    t_read(8'h3F, 8'h3F, "R5 read 6-bit 3F");
    check(cmd_bad == 0, "R2 preamble after 6-bit reads", cmd_bad, 0);

    do_reset();
    t_missing_part();

    do_reset();
    t_probe(8, 8'h00);
    t_wrong_marker();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule